// File: doc/BRIEF.md
# Dual-Write-Port Register File

This block is a general-purpose register file of 32 words by 32 bits. Two write ports can update registers on the same rising clock edge. Two read ports return register contents combinationally. Word 0 is wired to zero, so a write to it is discarded and a read of it returns zero.

The write side works in three steps. Each write port has its own select decoder. Each storage word takes an enable that is the OR of the two port hits. Each word has a two-way data select that prefers port 1. Because port 1 is preferred, port 1 data is stored when both ports name the same word in the same cycle. An active-high synchronous reset holds off every write for as long as it is asserted. It does not clear the stored words.

Top module: `dwrf_regfile`

## Requirements
- R1: When `wr1_en` is 1 and `wr1_sel` is nonzero, word `wr1_sel` holds `wr1_data` after the next rising clock edge.
- R2: When `wr2_en` is 1, `wr2_sel` is nonzero, and port 1 is not enabled on the same word, word `wr2_sel` holds `wr2_data` after the next rising clock edge.
- R3: When both ports are enabled on two different nonzero words, both words are updated on the same edge, each with its own port's data.
- R4: When both ports are enabled on the same nonzero word, that word holds `wr1_data` after the edge.
- R5: Word 0 always reads as zero on both read ports, whatever is written to it.
- R6: A word that no enabled write port selects keeps its value across the edge.
- R7: The read ports are combinational. A change of read select shows on the data output without a clock edge. In the cycle of a write, the read returns the old value until the edge.
- R8: While `rst` is 1, no write port changes any word.
- R9: The two read ports are independent and can read different words at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high write inhibit |
| wr1_en | input | 1 | Write enable of port 1 (priority port) |
| wr1_sel | input | 5 | Word selected by port 1 |
| wr1_data | input | 32 | Data of port 1 |
| wr2_en | input | 1 | Write enable of port 2 |
| wr2_sel | input | 5 | Word selected by port 2 |
| wr2_data | input | 32 | Data of port 2 |
| rd1_sel | input | 5 | Read port 1 word select |
| rd1_data | output | 32 | Read port 1 data |
| rd2_sel | input | 5 | Read port 2 word select |
| rd2_data | output | 32 | Read port 2 data |

## Verification
A write is due exactly one rising edge after its inputs are applied. The bench drives writes at the falling edge and reads the affected words 2 ns after the following rising edge. Read results have no latency, so they are sampled 1 ns after a change of read select, with no edge in between. For the same-cycle case, the bench samples once before the edge, expecting the old value, and once after it, expecting the new value. The both-port sweep covers every pair of selects, including all collisions and all writes to word 0.

// File: rtl/dwrf_pkg.sv
`timescale 1ns/1ps
package dwrf_pkg;
  localparam int unsigned DWRF_DEPTH = 32;
  localparam int unsigned DWRF_WIDTH = 32;
endpackage

// File: rtl/dwrf_wdec.sv
`timescale 1ns/1ps
// One-hot select decoder for a single write port; word 0 gets no line.
module dwrf_wdec #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              en,
  input  logic [AW-1:0]     sel,
  output logic [DEPTH-1:1]  hit
);
  for (genvar i = 1; i < DEPTH; i++) begin : g_line
    assign hit[i] = en && (sel == AW'(i));
  end
endmodule

// File: rtl/dwrf_cell.sv
`timescale 1ns/1ps
// One storage word with a load enable.
module dwrf_cell #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (en) q <= d;
  end
endmodule

// File: rtl/dwrf_rmux.sv
`timescale 1ns/1ps
// Combinational read selector over the flattened word array.
module dwrf_rmux #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]                 sel,
  input  logic [DEPTH-1:0][WIDTH-1:0]   words,
  output logic [WIDTH-1:0]              data
);
  assign data = words[sel];
endmodule

// File: rtl/dwrf_regfile.sv
`timescale 1ns/1ps
module dwrf_regfile
  import dwrf_pkg::*;
#(
  parameter int DEPTH = DWRF_DEPTH,
  parameter int WIDTH = DWRF_WIDTH,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr1_en,
  input  logic [AW-1:0]    wr1_sel,
  input  logic [WIDTH-1:0] wr1_data,
  input  logic             wr2_en,
  input  logic [AW-1:0]    wr2_sel,
  input  logic [WIDTH-1:0] wr2_data,
  input  logic [AW-1:0]    rd1_sel,
  output logic [WIDTH-1:0] rd1_data,
  input  logic [AW-1:0]    rd2_sel,
  output logic [WIDTH-1:0] rd2_data
);
  logic [DEPTH-1:1]            hit1, hit2;
  logic [DEPTH-1:0][WIDTH-1:0] words;

  dwrf_wdec #(.DEPTH(DEPTH)) u_dec1 (.en(wr1_en), .sel(wr1_sel), .hit(hit1));
  dwrf_wdec #(.DEPTH(DEPTH)) u_dec2 (.en(wr2_en), .sel(wr2_sel), .hit(hit2));

  // Word 0 is a constant; it has no storage and no write path.
  assign words[0] = '0;

  for (genvar i = 1; i < DEPTH; i++) begin : g_word
    logic             ld;
    logic [WIDTH-1:0] nxt;
    assign ld  = !rst && (hit1[i] || hit2[i]);
    assign nxt = hit1[i] ? wr1_data : wr2_data;   // port 1 wins on collision
    dwrf_cell #(.WIDTH(WIDTH)) u_cell (.clk(clk), .en(ld), .d(nxt), .q(words[i]));

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(hit1[i] || hit2[i]) |=> $stable(words[i]))
      else $error("unselected word changed"); // R6
  end

  dwrf_rmux #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd1 (.sel(rd1_sel), .words(words), .data(rd1_data));
  dwrf_rmux #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd2 (.sel(rd2_sel), .words(words), .data(rd2_data));

  AST_PORT1_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr1_en && wr1_sel != '0) |=> (words[$past(wr1_sel)] == $past(wr1_data)))
    else $error("port 1 data not stored"); // R4
  AST_PORT2_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr2_en && wr2_sel != '0 && !(wr1_en && wr1_sel == wr2_sel))
      |=> (words[$past(wr2_sel)] == $past(wr2_data)))
    else $error("port 2 data not stored"); // R2
  AST_ZERO_READ1: assert property (@(posedge clk) disable iff (rst)
    (rd1_sel == '0) |-> (rd1_data == '0))
    else $error("word 0 nonzero on read 1"); // R5
  AST_ZERO_READ2: assert property (@(posedge clk) disable iff (rst)
    (rd2_sel == '0) |-> (rd2_data == '0))
    else $error("word 0 nonzero on read 2"); // R5
  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit1) && $onehot0(hit2))
    else $error("decoder drives several lines"); // R6
endmodule

// File: tb/dwrf_regfile_bench.sv
`timescale 1ns/1ps
module dwrf_regfile_bench;
  localparam int DEPTH = 32;
  localparam int WIDTH = 32;
  localparam int AW    = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst = 1'b1;
  logic             wr1_en = 1'b0, wr2_en = 1'b0;
  logic [AW-1:0]    wr1_sel = '0, wr2_sel = '0, rd1_sel = '0, rd2_sel = '0;
  logic [WIDTH-1:0] wr1_data = '0, wr2_data = '0;
  logic [WIDTH-1:0] rd1_data, rd2_data;

  dwrf_regfile u_dwrf_regfile (
    .clk(clk), .rst(rst),
    .wr1_en(wr1_en), .wr1_sel(wr1_sel), .wr1_data(wr1_data),
    .wr2_en(wr2_en), .wr2_sel(wr2_sel), .wr2_data(wr2_data),
    .rd1_sel(rd1_sel), .rd1_data(rd1_data),
    .rd2_sel(rd2_sel), .rd2_data(rd2_data));

  logic [WIDTH-1:0] model [DEPTH];
  int n_chk = 0;
  int n_fail = 0;

  function automatic logic [WIDTH-1:0] pat(int a, int salt);
    return (WIDTH'(a) * 32'h9E37_79B9) ^ WIDTH'(salt * 32'h0101_0F0F);
  endfunction

  function automatic logic [WIDTH-1:0] want(int a);
    return (a == 0) ? '0 : model[a];
  endfunction

  task automatic chk(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, commit at the rising edge, release after it.
  task automatic wr(logic e1, int a1, logic [WIDTH-1:0] d1,
                    logic e2, int a2, logic [WIDTH-1:0] d2);
    @(negedge clk);
    wr1_en = e1; wr1_sel = AW'(a1); wr1_data = d1;
    wr2_en = e2; wr2_sel = AW'(a2); wr2_data = d2;
    if (!rst) begin
      if (e2 && a2 != 0) model[a2] = d2;
      if (e1 && a1 != 0) model[a1] = d1;   // port 1 applied last: it wins
    end
    @(posedge clk);
    #1;
    wr1_en = 1'b0; wr2_en = 1'b0;
    #1;
  endtask

  task automatic scan(string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd1_sel = AW'(a); rd2_sel = AW'(DEPTH - 1 - a);
      #1;
      chk(req, rd1_data, want(a));
      chk(req, rd2_data, want(DEPTH - 1 - a));
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    repeat (3) @(posedge clk);
    #2;
    rd1_sel = '0; rd2_sel = '0; #1;
    chk("R5 reset", rd1_data, '0);
    chk("R5 reset", rd2_data, '0);
    @(negedge clk); rst = 1'b0;

    // R1: port 1 alone fills every word
    for (int a = 1; a < DEPTH; a++) wr(1'b1, a, pat(a, 1), 1'b0, 0, '0);
    scan("R1");
    // R2: port 2 alone overwrites every word
    for (int a = 1; a < DEPTH; a++) wr(1'b0, 0, '0, 1'b1, a, pat(a, 2));
    scan("R2");
    // R3: two distinct words on one edge, R6 for the rest
    wr(1'b1, 3, 32'hA5A5_0003, 1'b1, 9, 32'h5A5A_0009);
    scan("R3 R6");
    // R5: both ports aim at word 0
    wr(1'b1, 0, 32'hFFFF_FFFF, 1'b1, 0, 32'hEEEE_EEEE);
    scan("R5");

    // Full select sweep with both ports enabled (R3/R4/R5)
    for (int a = 0; a < DEPTH; a++) begin
      for (int b = 0; b < DEPTH; b++) begin
        wr(1'b1, a, pat(a * 64 + b, 3), 1'b1, b, pat(a * 64 + b, 4));
        rd1_sel = AW'(a); rd2_sel = AW'(b); #1;
        chk((a == b) ? "R4" : "R3", rd1_data, want(a));
        chk((a == b) ? "R4" : "R3", rd2_data, want(b));
      end
    end

    // Enable combinations on a small window (R1/R2/R6)
    for (int e = 0; e < 4; e++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          wr(e[0], a, pat(a + b * 8, 5 + e), e[1], b, pat(a + b * 8, 9 + e));
          rd1_sel = AW'(a); rd2_sel = AW'(b); #1;
          chk("R6", rd1_data, want(a));
          chk("R6", rd2_data, want(b));
        end
      end
    end
    scan("R6");

    // R7: old value before the edge, new value after; address change without edge
    @(negedge clk);
    wr1_en = 1'b1; wr1_sel = AW'(7); wr1_data = 32'hC0DE_0007;
    rd1_sel = AW'(7); rd2_sel = AW'(8); #1;
    chk("R7 pre-edge", rd1_data, model[7]);
    chk("R9", rd2_data, model[8]);
    model[7] = 32'hC0DE_0007;
    @(posedge clk); #1; wr1_en = 1'b0; #1;
    chk("R7 post-edge", rd1_data, model[7]);
    rd1_sel = AW'(12); #1;
    chk("R7 sel change", rd1_data, model[12]);

    // R8: writes held off during reset
    rst = 1'b1;
    wr(1'b1, 4, 32'hDEAD_0004, 1'b1, 5, 32'hDEAD_0005);
    wr(1'b1, 6, 32'hDEAD_0006, 1'b0, 0, '0);
    scan("R8");
    @(negedge clk); rst = 1'b0;
    wr(1'b1, 4, 32'h1234_0004, 1'b0, 0, '0);
    scan("R9");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule